// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, once per received frame, whether the frame is kept. It reads the six destination address bytes as they arrive. Each byte comes with a valid flag, and the first byte also carries a start strobe. The decision depends on a programmable station address, a 64-bin multicast hash table and three mode bits: promiscuous, accept-all-multicast and hashed-multicast.

A CRC-32 is run over the address bytes as they stream in. Its top bits pick one bin of the hash table. The accept/reject result and the bin index appear together on a one-cycle strobe, so the receive path can drop a frame before its payload is stored. Configuration is loaded through three plain write ports that hold their values until rewritten or reset.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, dec_vld_o, accept_o and hash_idx_o are all zero, the station address and the hash table are zero, and all three mode bits are cleared.
- R2: A cycle with sof_i and byte_vld_i both high carries address byte 1. The next five cycles with byte_vld_i high carry bytes 2 to 6, and idle cycles may fall between them. dec_vld_o is high for exactly one cycle, the cycle after byte 6 is sampled.
- R3: Valid bytes after byte 6, and valid bytes without sof_i while no address is in progress, produce no decision. A sof_i during an address restarts collection from that byte.
- R4: With each decision, hash_idx_o equals bits 31:26 of a CRC-32 over the six bytes. The CRC uses polynomial 0x04C11DB7, starts from all ones, has no final inversion and takes each byte least significant bit first.
- R5: A unicast frame, where bit 0 of byte 1 is 0, is accepted when promiscuous mode is off only if all six bytes equal the station address. Byte 1 is compared with station bits 47:40 and byte 6 with bits 7:0.
- R6: The broadcast address FF:FF:FF:FF:FF:FF is accepted in every mode.
- R7: With accept-all-multicast set (mode_i bit 1), every multicast frame is accepted, whatever the hash table holds.
- R8: A non-broadcast multicast frame, with accept-all-multicast and promiscuous both clear, is accepted only when hashed-multicast is set (mode_i bit 0) and table bit hash_idx_o is 1.
- R9: With promiscuous set (mode_i bit 2), every frame is accepted.
- R10: accept_o is 0 in every cycle where dec_vld_o is 0.
- R11: A configuration write sampled at a clock edge before the edge that samples byte 6 governs that frame's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| station_we_i | input | 1 | Load station address |
| station_addr_i | input | 48 | Station address, first byte in bits 47:40 |
| hash_we_i | input | 1 | Load hash table |
| hash_tbl_i | input | 64 | Hash table, bit n is bin n |
| mode_we_i | input | 1 | Load mode bits |
| mode_i | input | 3 | Bit 2 promiscuous, bit 1 all-multicast, bit 0 hashed-multicast |
| sof_i | input | 1 | Marks the first address byte |
| byte_vld_i | input | 1 | byte_i carries an address byte |
| byte_i | input | 8 | Address byte |
| dec_vld_o | output | 1 | One-cycle decision strobe |
| accept_o | output | 1 | Frame accepted, qualified by dec_vld_o |
| hash_idx_o | output | 6 | Hash bin of the last address |

## Verification
The assertions assume that sof_i is only used together with byte_vld_i. They also assume that a decision can only follow a sampled byte, so two strobes can never come in back-to-back cycles. The bench keeps to this by driving sof_i only on the first valid byte. It changes the mode only between frames, except in the one case where the timing of a write is itself under test. Inputs are driven on falling edges, and outputs are sampled one falling edge after byte 6.

// File: rtl/rx_af_pkg.sv
package rx_af_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

  typedef struct packed {
    logic promisc;
    logic all_mcast;
    logic hash_en;
  } af_mode_t;

  // shift-left register, data bits fed lsb first
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/rx_af_cfg.sv
module rx_af_cfg
  import rx_af_pkg::*;
#(
  parameter int ADW   = ADDR_W,
  parameter int TBL_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             station_we_i,
  input  logic [ADW-1:0]   station_addr_i,
  input  logic             hash_we_i,
  input  logic [TBL_W-1:0] hash_tbl_i,
  input  logic             mode_we_i,
  input  af_mode_t         mode_i,
  output logic [ADW-1:0]   station_o,
  output logic [TBL_W-1:0] tbl_o,
  output af_mode_t         mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      station_o <= '0;
      tbl_o     <= '0;
      mode_o    <= '0;
    end else begin
      if (station_we_i) station_o <= station_addr_i;
      if (hash_we_i)    tbl_o     <= hash_tbl_i;
      if (mode_we_i)    mode_o    <= mode_i;
    end
  end
endmodule

// File: rtl/rx_af_track.sv
module rx_af_track
  import rx_af_pkg::*;
#(
  parameter int NBYTES = ADDR_BYTES,
  localparam int ADW   = 8 * NBYTES,
  localparam int CNT_W = $clog2(NBYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic [ADW-1:0]   station_i,
  output logic             last_o,
  output logic [CRC_W-1:0] crc_o,
  output logic             match_o,
  output logic             bcast_o,
  output logic             mcast_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q, idx;
  logic [CRC_W-1:0] crc_q;
  logic             match_q, bcast_q, mcast_q;
  logic             take;
  logic [7:0]       stn_byte;

  assign take = byte_vld_i && (sof_i || busy_q);
  assign idx  = sof_i ? '0 : cnt_q;

  always_comb begin
    stn_byte = '0;
    for (int b = 0; b < NBYTES; b++)
      if (idx == CNT_W'(b)) stn_byte = station_i[ADW-1-8*b -: 8];
  end

  assign crc_o   = crc_byte(sof_i ? '1 : crc_q, byte_i);
  assign match_o = (sof_i | match_q) & (byte_i == stn_byte);
  assign bcast_o = (sof_i | bcast_q) & (byte_i == 8'hFF);
  assign mcast_o = sof_i ? byte_i[0] : mcast_q;
  assign last_o  = take && (idx == CNT_W'(NBYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      crc_q   <= '0;
      match_q <= 1'b0;
      bcast_q <= 1'b0;
      mcast_q <= 1'b0;
    end else if (take) begin
      busy_q  <= !last_o;
      cnt_q   <= idx + 1'b1;
      crc_q   <= crc_o;
      match_q <= match_o;
      bcast_q <= bcast_o;
      mcast_q <= mcast_o;
    end
  end
endmodule

// File: rtl/rx_af_decide.sv
module rx_af_decide
  import rx_af_pkg::*;
#(
  parameter int HASH_BITS = 6,
  localparam int TBL_W    = 1 << HASH_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 last_i,
  input  af_mode_t             mode_i,
  input  logic [TBL_W-1:0]     tbl_i,
  input  logic [CRC_W-1:0]     crc_i,
  input  logic                 match_i,
  input  logic                 bcast_i,
  input  logic                 mcast_i,
  output logic                 dec_vld_o,
  output logic                 accept_o,
  output logic [HASH_BITS-1:0] hash_idx_o
);
  logic [HASH_BITS-1:0] bin;
  logic                 keep;

  assign bin = crc_i[CRC_W-1 -: HASH_BITS];

  always_comb begin
    if (mode_i.promisc || bcast_i) keep = 1'b1;
    else if (mcast_i)              keep = mode_i.all_mcast || (mode_i.hash_en && tbl_i[bin]);
    else                           keep = match_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_vld_o  <= 1'b0;
      accept_o   <= 1'b0;
      hash_idx_o <= '0;
    end else begin
      dec_vld_o <= last_i;
      accept_o  <= last_i && keep;
      if (last_i) hash_idx_o <= bin;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_af_pkg::*;
#(
  parameter int HASH_BITS = 6,
  localparam int TBL_W    = 1 << HASH_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 station_we_i,
  input  logic [ADDR_W-1:0]    station_addr_i,
  input  logic                 hash_we_i,
  input  logic [TBL_W-1:0]     hash_tbl_i,
  input  logic                 mode_we_i,
  input  logic [2:0]           mode_i,
  input  logic                 sof_i,
  input  logic                 byte_vld_i,
  input  logic [7:0]           byte_i,
  output logic                 dec_vld_o,
  output logic                 accept_o,
  output logic [HASH_BITS-1:0] hash_idx_o
);
  logic [ADDR_W-1:0] station_q;
  logic [TBL_W-1:0]  tbl_q;
  af_mode_t          mode_q;
  logic              last;
  logic [CRC_W-1:0]  crc_nxt;
  logic              match_nxt, bcast_nxt, mcast_nxt;

  rx_af_cfg #(.ADW(ADDR_W), .TBL_W(TBL_W)) u_cfg (
    .clk_i, .rst_ni,
    .station_we_i, .station_addr_i,
    .hash_we_i, .hash_tbl_i,
    .mode_we_i, .mode_i(af_mode_t'(mode_i)),
    .station_o(station_q), .tbl_o(tbl_q), .mode_o(mode_q)
  );

  rx_af_track #(.NBYTES(ADDR_BYTES)) u_track (
    .clk_i, .rst_ni, .sof_i, .byte_vld_i, .byte_i,
    .station_i(station_q),
    .last_o(last), .crc_o(crc_nxt),
    .match_o(match_nxt), .bcast_o(bcast_nxt), .mcast_o(mcast_nxt)
  );

  rx_af_decide #(.HASH_BITS(HASH_BITS)) u_decide (
    .clk_i, .rst_ni, .last_i(last), .mode_i(mode_q), .tbl_i(tbl_q),
    .crc_i(crc_nxt), .match_i(match_nxt), .bcast_i(bcast_nxt), .mcast_i(mcast_nxt),
    .dec_vld_o, .accept_o, .hash_idx_o
  );
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int HASH_BITS = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 byte_vld_i,
  input logic                 promisc_q,
  input logic                 dec_vld_o,
  input logic                 accept_o,
  input logic [HASH_BITS-1:0] hash_idx_o
);
  // R2
  dec_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o |=> !dec_vld_o);
  // R2
  dec_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o |-> $past(byte_vld_i));
  // R10
  acc_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_vld_o |-> !accept_o);
  // R9
  promisc_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o && $past(promisc_q) |-> accept_o);
  // R4
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_vld_o |-> $stable(hash_idx_o));
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.HASH_BITS(HASH_BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_vld_i(byte_vld_i),
  .promisc_q(mode_q.promisc), .dec_vld_o(dec_vld_o),
  .accept_o(accept_o), .hash_idx_o(hash_idx_o)
);

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        station_we_i = 0, hash_we_i = 0, mode_we_i = 0;
  logic [47:0] station_addr_i = '0;
  logic [63:0] hash_tbl_i = '0;
  logic [2:0]  mode_i = '0;
  logic        sof_i = 0, byte_vld_i = 0;
  logic [7:0]  byte_i = '0;
  logic        dec_vld_o, accept_o;
  logic [5:0]  hash_idx_o;

  int checks = 0, errors = 0;
  logic [47:0] stn;
  logic [63:0] tbl;
  logic [2:0]  md;
  logic        got_v, got_a;
  logic [5:0]  got_i;

  always #(CLK_P/2) clk_i = ~clk_i;

  rx_addr_filter dut_i (.*);

  function automatic logic [5:0] ref_bin(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      logic bit_in = a[47 - 8*(k/8) - 7 + (k%8)];
      logic top = c[31];
      c = c << 1;
      if (top != bit_in) c = c ^ 32'h04C11DB7;
    end
    return c[31:26];
  endfunction

  function automatic logic ref_acc(input logic [47:0] a);
    if (md[2] || a == 48'hFFFF_FFFF_FFFF) return 1'b1;
    if (a[40]) return md[1] | (md[0] & tbl[ref_bin(a)]);
    return a == stn;
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic cfg(input logic [47:0] s, input logic [63:0] t, input logic [2:0] m);
    @(negedge clk_i);
    station_we_i = 1; station_addr_i = s; hash_we_i = 1; hash_tbl_i = t;
    mode_we_i = 1; mode_i = m;
    stn = s; tbl = t; md = m;
    @(negedge clk_i);
    station_we_i = 0; hash_we_i = 0; mode_we_i = 0;
  endtask

  task automatic send(input logic [47:0] a, input int gap);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      sof_i = (i == 0); byte_vld_i = 1; byte_i = a[47-8*i -: 8];
      if (i < 5) for (int g = 0; g < gap; g++) begin
        @(negedge clk_i); sof_i = 0; byte_vld_i = 0;
      end
    end
    @(negedge clk_i);
    sof_i = 0; byte_vld_i = 0;
    got_v = dec_vld_o; got_a = accept_o; got_i = hash_idx_o;
  endtask

  task automatic frame(input string r, input logic [47:0] a, input int gap);
    send(a, gap);
    chk({r, " strobe"}, 64'(got_v), 64'd1);
    chk({r, " accept"}, 64'(got_a), 64'(ref_acc(a)));
    chk("R4 bin", 64'(got_i), 64'(ref_bin(a)));
    @(negedge clk_i);
    chk("R2 pulse", 64'(dec_vld_o), 64'd0);
    chk("R10 qual", 64'(accept_o), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] a;
    repeat (3) @(negedge clk_i);
    chk("R1 vld", 64'(dec_vld_o), 0);
    chk("R1 acc", 64'(accept_o), 0);
    chk("R1 idx", 64'(hash_idx_o), 0);
    rst_ni = 1;
    // R1: cleared config: station 0 unicast matches, multicast rejected
    stn = '0; tbl = '0; md = '0;
    frame("R1 zero station", 48'h0, 0);
    frame("R1 mcast off", 48'h0100_5E00_0001, 0);

    cfg(48'h0A1B_2C3D_4E5F, 64'hA5C3_0F96_3C5A_E187, 3'b001);
    frame("R5 exact", 48'h0A1B_2C3D_4E5F, 0);
    frame("R2 gaps", 48'h0A1B_2C3D_4E5F, 2);
    for (int p = 0; p < 6; p++)
      frame("R5 mismatch", 48'h0A1B_2C3D_4E5F ^ (48'h10 << (8*p)), p % 2);
    frame("R6 bcast", 48'hFFFF_FFFF_FFFF, 0);
    for (int k = 0; k < 96; k++)
      frame("R8 hash", {24'h01005E, 8'h00, 8'(k * 7), 8'(k)}, 0);
    cfg(48'h0A1B_2C3D_4E5F, 64'hA5C3_0F96_3C5A_E187, 3'b000);
    for (int k = 0; k < 8; k++) frame("R8 off", {40'h3300_0000_00, 8'(k)}, 0);
    frame("R6 bcast", 48'hFFFF_FFFF_FFFF, 0);
    cfg(48'h0A1B_2C3D_4E5F, 64'h0, 3'b010);
    for (int k = 0; k < 16; k++) frame("R7 allmc", {40'h0100_5E7F_00, 8'(k*13)}, 1);
    frame("R7 uc miss", 48'h0A1B_2C3D_4E50, 0);
    cfg(48'h0A1B_2C3D_4E5F, 64'h0, 3'b100);
    for (int k = 0; k < 16; k++) frame("R9 promisc", {8'(2*k), 40'h1234_5678_9A}, 0);
    frame("R9 mcast", 48'h0100_5E00_0042, 0);

    // R3: stray bytes while idle, trailing bytes, restart
    cfg(48'h0A1B_2C3D_4E5F, 64'h0, 3'b000);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i); byte_vld_i = 1; byte_i = 8'(k);
      chk("R3 idle", 64'(dec_vld_o), 0);
    end
    @(negedge clk_i); byte_vld_i = 0;
    chk("R3 idle", 64'(dec_vld_o), 0);
    send(48'h0A1B_2C3D_4E5F, 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i); byte_vld_i = 1; byte_i = 8'h5A;
      chk("R3 trail", 64'(dec_vld_o), 0);
    end
    @(negedge clk_i); byte_vld_i = 0;
    chk("R3 trail", 64'(dec_vld_o), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i); sof_i = (k == 0); byte_vld_i = 1; byte_i = 8'hEE;
    end
    frame("R3 restart", 48'h0A1B_2C3D_4E5F, 0);

    // R11: table write sampled before byte 6 governs the frame
    md = 3'b001; tbl = '1;
    @(negedge clk_i); mode_we_i = 1; mode_i = 3'b001; hash_we_i = 1; hash_tbl_i = '1;
    a = 48'h0100_5E01_0203;
    for (int i = 0; i < 6; i++) begin
      if (i > 0) @(negedge clk_i);
      if (i == 1) begin mode_we_i = 0; hash_we_i = 0; end
      sof_i = (i == 0); byte_vld_i = 1; byte_i = a[47-8*i -: 8];
    end
    @(negedge clk_i); sof_i = 0; byte_vld_i = 0;
    chk("R11 late cfg", 64'(accept_o), 64'd1);
    tbl = '0;
    @(negedge clk_i); hash_we_i = 1; hash_tbl_i = '0;
    @(negedge clk_i); hash_we_i = 0;
    frame("R11 cleared", a, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule